// File: doc/BRIEF.md
# Dual-Channel UART Sleep and Wake Controller

This block decides when a two-channel UART may stop its reference oscillator and when it must restart it. It runs on a free-running control clock. It watches, for both channels together, the interrupt-pending flags, the sleep-enable bits, the RX line levels, the host's transmit writes and the modem-control inputs (clear-to-send, data-set-ready, carrier-detect and ring-indicate). It keeps the per-channel modem-change flags itself. A read of a channel's modem status clears that channel's flags.

The controller has four states:
- `ST_RUN`: oscillator on, clock ready.
- `ST_QUAL`: the entry conditions are being qualified.
- `ST_SLEEP`: oscillator stopped.
- `ST_WARM`: oscillator restarted, start-up wait running.

It moves between them on these transitions:
- `ST_RUN` → `ST_QUAL`: every entry condition holds and no wake event is seen.
- `ST_QUAL` → `ST_RUN`: the qualification is cancelled because a condition drops or a wake event arrives.
- `ST_QUAL` → `ST_SLEEP`: the conditions have held for `QUAL_CYC` cycles in `ST_QUAL`.
- `ST_SLEEP` → `ST_WARM`: a wake event, or the loss of any entry condition.
- `ST_WARM` → `ST_RUN`: `STARTUP_CYC` cycles have passed.

After every wake the controller returns to sleep without host action, as soon as all conditions hold again. Clearing either channel's sleep-enable keeps it awake.

Top module: `duart_sleep_ctrl`

## Requirements
- R1: After reset `osc_en`=1, `clk_ready`=1, `asleep`=0 and `mdelta`=0.
- R2: Sleep (`asleep`=1, `osc_en`=0, `clk_ready`=0) is reached only when all of the following hold on both channels: `irq_none`=1, `sleep_en`=1, `rx`=1 and `mdelta`=0. If any one of them is missing on any channel, the block stays awake.
- R3: The entry conditions must hold for `QUAL_CYC` consecutive cycles in `ST_QUAL` before the oscillator stops. A drop in any condition, or a wake event, during that time cancels the entry.
- R4: A high-to-low transition on either `rx` bit wakes the block from sleep: `osc_en`=1, `asleep`=0 and `clk_ready`=0.
- R5: A one-cycle pulse on either `tx_wr` bit wakes the block from sleep on the next clock edge.
- R6: A level change on a modem input sets its bit in `mdelta` and wakes the block. The bit positions are: channel A in bits [3:0], channel B in bits [7:4]; within each channel, bit 0 is clear-to-send, bit 1 is data-set-ready, bit 2 is carrier-detect and bit 3 is ring-indicate.
- R7: `msr_rd[c]` clears only the four `mdelta` bits of channel c. While any `mdelta` bit is set, sleep is not entered.
- R8: After a wake, `clk_ready` stays 0 for exactly `STARTUP_CYC` cycles and then returns to 1.
- R9: After a wake the block goes back to sleep by itself once all entry conditions hold again. No host action is needed.
- R10: While either `sleep_en` bit is 0 the block is awake. Clearing one of these bits during sleep forces a wake.
- R11: `asleep` is 1 exactly when `osc_en` is 0, and `clk_ready` is never 1 while `osc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_none | input | 2 | Per channel: 1 = no interrupt pending |
| sleep_en | input | 2 | Per channel sleep-enable bit |
| rx | input | 2 | Raw RX line levels (asynchronous) |
| modem_in | input | 8 | Raw modem inputs, 4 per channel (asynchronous) |
| tx_wr | input | 2 | Per channel transmit-write strobe |
| msr_rd | input | 2 | Per channel modem-status read strobe |
| osc_en | output | 1 | Reference oscillator enable |
| clk_ready | output | 1 | Oscillator stable, UART activity allowed |
| asleep | output | 1 | Oscillator stopped |
| mdelta | output | 8 | Latched modem-change flags |

## Verification
The checker tests the following on every cycle:
- the output relations (R11);
- that sleep never starts without the port-visible entry conditions on the previous cycle (R2);
- that no modem-change flag coexists with sleep (R7);
- that a cleared sleep-enable forbids sleep on the next cycle (R10);
- with a cycle counter, that `clk_ready` rises exactly `STARTUP_CYC` cycles after the oscillator restarts (R8).

Only the bench scenarios can show the following:
- that each wake source actually restarts the oscillator;
- that interrupted qualification never reaches sleep;
- that a modem-status read clears only its own channel;
- that sleep returns automatically after each wake.

// File: rtl/duart_slp_pkg.sv
package duart_slp_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_QUAL  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_WARM  = 2'd3
    } slp_state_t;
endpackage

// File: rtl/dslp_sync.sv
module dslp_sync #(
    parameter int          W       = 1,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= {W{RST_VAL}};
            q      <= {W{RST_VAL}};
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/dslp_wake.sv
module dslp_wake #(
    parameter int NCH = 2,
    parameter int MW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    rx_raw,
    input  logic [NCH*MW-1:0] modem_raw,
    input  logic [NCH-1:0]    tx_wr,
    input  logic [NCH-1:0]    msr_rd,
    output logic              rx_idle,
    output logic              wake_evt,
    output logic [NCH*MW-1:0] mdelta
);
    localparam int MT = NCH * MW;

    logic [NCH-1:0] rx_cur, rx_prev;
    logic [MT-1:0]  md_cur, md_prev;
    logic [MT-1:0]  md_change, md_clear;
    logic [1:0]     arm_cnt;
    logic           armed;
    logic           rx_fall;

    dslp_sync #(.W(NCH), .RST_VAL(1'b1)) u_rx_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_raw), .q(rx_cur)
    );

    dslp_sync #(.W(MT), .RST_VAL(1'b0)) u_md_sync (
        .clk(clk), .rst_n(rst_n), .d(modem_raw), .q(md_cur)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_prev <= '1;
            md_prev <= '0;
            arm_cnt <= '0;
        end else begin
            rx_prev <= rx_cur;
            md_prev <= md_cur;
            if (arm_cnt != 2'd3) arm_cnt <= arm_cnt + 2'd1;
        end
    end

    assign armed = (arm_cnt == 2'd3);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_clr
            assign md_clear[c*MW +: MW] = {MW{msr_rd[c]}};
        end
    endgenerate

    assign md_change = armed ? (md_cur ^ md_prev) : '0;
    assign rx_fall   = armed & |(rx_prev & ~rx_cur);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mdelta <= '0;
        else        mdelta <= (mdelta & ~md_clear) | md_change;
    end

    assign rx_idle  = &rx_cur;
    assign wake_evt = rx_fall | (|tx_wr) | (|md_change);
endmodule

// File: rtl/dslp_fsm.sv
module dslp_fsm
    import duart_slp_pkg::*;
#(
    parameter int QUAL_CYC    = 4,
    parameter int STARTUP_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic entry_ok,
    input  logic wake_evt,
    output logic osc_en,
    output logic clk_ready,
    output logic asleep
);
    localparam int MAXC = (QUAL_CYC > STARTUP_CYC) ? QUAL_CYC : STARTUP_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] QUAL_LAST = CW'(QUAL_CYC - 1);
    localparam logic [CW-1:0] WARM_LAST = CW'(STARTUP_CYC - 1);

    slp_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          go;

    assign go = entry_ok & ~wake_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                cnt_d = '0;
                if (go) state_d = ST_QUAL;
            end
            ST_QUAL: begin
                if (!go) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else if (cnt_q == QUAL_LAST) begin
                    state_d = ST_SLEEP;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SLEEP: begin
                cnt_d = '0;
                if (!go) state_d = ST_WARM;
            end
            ST_WARM: begin
                if (cnt_q == WARM_LAST) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        osc_en    = 1'b1;
        clk_ready = 1'b1;
        asleep    = 1'b0;
        unique case (state_q)
            ST_RUN, ST_QUAL: ;
            ST_SLEEP: begin
                osc_en    = 1'b0;
                clk_ready = 1'b0;
                asleep    = 1'b1;
            end
            ST_WARM: clk_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/duart_sleep_ctrl.sv
module duart_sleep_ctrl #(
    parameter int NCH         = 2,
    parameter int MW          = 4,
    parameter int QUAL_CYC    = 4,
    parameter int STARTUP_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    irq_none,
    input  logic [NCH-1:0]    sleep_en,
    input  logic [NCH-1:0]    rx,
    input  logic [NCH*MW-1:0] modem_in,
    input  logic [NCH-1:0]    tx_wr,
    input  logic [NCH-1:0]    msr_rd,
    output logic              osc_en,
    output logic              clk_ready,
    output logic              asleep,
    output logic [NCH*MW-1:0] mdelta
);
    logic rx_idle, wake_evt, entry_ok;

    dslp_wake #(.NCH(NCH), .MW(MW)) u_wake (
        .clk(clk), .rst_n(rst_n), .rx_raw(rx), .modem_raw(modem_in),
        .tx_wr(tx_wr), .msr_rd(msr_rd), .rx_idle(rx_idle),
        .wake_evt(wake_evt), .mdelta(mdelta)
    );

    assign entry_ok = (&irq_none) & (&sleep_en) & ~(|mdelta) & rx_idle;

    dslp_fsm #(.QUAL_CYC(QUAL_CYC), .STARTUP_CYC(STARTUP_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .entry_ok(entry_ok), .wake_evt(wake_evt),
        .osc_en(osc_en), .clk_ready(clk_ready), .asleep(asleep)
    );
endmodule

// File: rtl/dslp_chk.sv
module dslp_chk #(
    parameter int NCH         = 2,
    parameter int MW          = 4,
    parameter int STARTUP_CYC = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    irq_none,
    input logic [NCH-1:0]    sleep_en,
    input logic [NCH*MW-1:0] mdelta,
    input logic              osc_en,
    input logic              clk_ready,
    input logic              asleep
);
    localparam int SW = $clog2(STARTUP_CYC + 2);

    logic [SW-1:0] warm_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  warm_cnt <= '0;
        else if (osc_en && !clk_ready) warm_cnt <= warm_cnt + 1'b1;
        else                         warm_cnt <= '0;
    end

    // R11
    asleep_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep == !osc_en);

    // R11
    ready_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_ready |-> osc_en);

    // R2
    entry_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past((&irq_none) && (&sleep_en) && (mdelta == '0)));

    // R7
    no_sleep_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (mdelta == '0));

    // R10
    enable_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&sleep_en) |=> !asleep);

    // R8
    warm_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_ready) |-> (warm_cnt == SW'(STARTUP_CYC)));
endmodule

bind duart_sleep_ctrl dslp_chk #(
    .NCH(NCH), .MW(MW), .STARTUP_CYC(STARTUP_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_none(irq_none), .sleep_en(sleep_en),
    .mdelta(mdelta), .osc_en(osc_en), .clk_ready(clk_ready), .asleep(asleep)
);

// File: tb/duart_sleep_ctrl_bench.sv
module duart_sleep_ctrl_bench;
    localparam int QUAL = 4;
    localparam int WARM = 64;
    localparam int NVEC = 11;
    // fields: {irq_none[1:0], sleep_en[1:0], rx[1:0], expected asleep}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b11_11_11_1, 7'b10_11_11_0, 7'b11_11_11_1, 7'b01_11_11_0,
        7'b11_11_11_1, 7'b11_01_11_0, 7'b11_11_11_1, 7'b11_11_10_0,
        7'b11_11_11_1, 7'b00_00_00_0, 7'b11_11_11_1
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] irq_none = 2'b11, sleep_en = 2'b11, rx = 2'b11;
    logic [1:0] tx_wr = 2'b00, msr_rd = 2'b00;
    logic [7:0] modem_in = 8'h00;
    logic       osc_en, clk_ready, asleep;
    logic [7:0] mdelta;
    int         checks = 0, failures = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    duart_sleep_ctrl #(.QUAL_CYC(QUAL), .STARTUP_CYC(WARM)) u_duart_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_none(irq_none), .sleep_en(sleep_en),
        .rx(rx), .modem_in(modem_in), .tx_wr(tx_wr), .msr_rd(msr_rd),
        .osc_en(osc_en), .clk_ready(clk_ready), .asleep(asleep), .mdelta(mdelta)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_state(input string req, input logic exp_sleep, input logic exp_ready);
        chk(req, {29'd0, asleep, osc_en, clk_ready}, {29'd0, exp_sleep, !exp_sleep, exp_ready});
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int low_cnt;
        bit seen;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {29'd0, asleep, osc_en, clk_ready}, 32'h3);
        chk("R1 mdelta", {24'd0, mdelta}, 32'h0);

        // R2 table of entry-condition combinations
        for (int i = 0; i < NVEC; i++) begin
            {irq_none, sleep_en, rx} = VEC[i][6:1];
            cyc(100);
            chk_state($sformatf("R2 vector %0d", i), VEC[i][0], !VEC[i][0]);
        end

        // R3 interrupted qualification never sleeps
        irq_none = 2'b10;
        cyc(100);
        seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
            irq_none = 2'b11;
            for (int j = 0; j < 3; j++) begin @(negedge clk); seen |= asleep; end
            irq_none = 2'b10;
            @(negedge clk); seen |= asleep;
        end
        chk("R3 cancelled entry", {31'd0, seen}, 32'd0);
        irq_none = 2'b11;
        cyc(30);
        chk_state("R3 steady entry sleeps", 1'b1, 1'b0);

        // R5 transmit write wakes, R8 start-up length, R9 auto re-entry
        tx_wr = 2'b10;
        @(negedge clk);
        tx_wr = 2'b00;
        chk_state("R5 tx write wake", 1'b0, 1'b0);
        low_cnt = 1;
        while (!clk_ready && low_cnt < 500) begin @(negedge clk); if (!clk_ready) low_cnt++; end
        chk("R8 start-up cycles", low_cnt, WARM);
        cyc(30);
        chk_state("R9 re-sleep after tx wake", 1'b1, 1'b0);

        // R4 RX falling edge wakes
        rx = 2'b10;
        cyc(5);
        chk_state("R4 rx fall wake", 1'b0, 1'b0);
        rx = 2'b11;
        cyc(WARM + 30);
        chk_state("R9 re-sleep after rx wake", 1'b1, 1'b0);

        // R6 modem change on channel B data-set-ready (bit 5)
        modem_in = 8'h20;
        cyc(6);
        chk("R6 mdelta bit", {24'd0, mdelta}, 32'h20);
        chk("R6 wake", {31'd0, osc_en}, 32'd1);
        cyc(WARM + 40);
        chk_state("R7 no sleep with flag set", 1'b0, 1'b1);
        msr_rd = 2'b01;
        @(negedge clk);
        msr_rd = 2'b00;
        cyc(20);
        chk("R7 other channel read keeps flag", {24'd0, mdelta}, 32'h20);
        chk_state("R7 still awake", 1'b0, 1'b1);
        msr_rd = 2'b10;
        @(negedge clk);
        msr_rd = 2'b00;
        chk("R7 own channel read clears", {24'd0, mdelta}, 32'h0);
        cyc(30);
        chk_state("R9 re-sleep after modem read", 1'b1, 1'b0);

        // R10 clearing a sleep enable wakes and holds awake
        sleep_en = 2'b10;
        @(negedge clk);
        chk("R10 immediate wake", {31'd0, asleep}, 32'd0);
        cyc(200);
        chk_state("R10 held awake", 1'b0, 1'b1);
        sleep_en = 2'b11;
        cyc(30);
        chk_state("R10 re-enabled sleeps", 1'b1, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule